// File: doc/BRIEF.md
# Transmit User-Bit Double Buffer

This block holds the user-data bits that an S/PDIF-style transmitter sends, one bit per frame. A host loads bytes into a staging buffer through an 8-bit register pair. One register selects the byte, and the other carries the data. At each block boundary the whole staging buffer is copied into an active buffer. The serializer then reads the active buffer from bit 0, starting on the frame that carries the Z preamble. The host can therefore prepare the next block while the current one goes out.

A 2-bit mode input selects how the stored bytes become user bits: all zeros, plain fill, information-unit framing, or a 10-byte Q-subcode area. A 1-bit size input selects a block length of 384 or 768 bits. Two sticky flags tell the host that a block has been taken and that the staging buffer is full. A status read clears both flags. Each flag reaches the interrupt output only when its mask input is set.

Top module: `ubuf_top`

## Requirements
- R1: With mode 00, every frame sends a user bit of 0, whatever the buffers hold.
- R2: With mode 01, byte n of the block supplies user bits 8n to 8n+7, least significant bit first.
- R3: The bit position wraps to 0 after 384 frames when the size input is 0 and after 768 frames when it is 1, even if no Z frame arrives. With size 1 the wrap does not happen at 384.
- R4: With mode 10, each byte forms one 8-bit information unit: a 1 start bit, then byte bits 6 down to 0.
- R5: With mode 11, bytes 0 to 9 are sent as in mode 01 and all later bytes are sent as zeros. The staging buffer becomes full after 10 accepted writes.
- R6: A write to address 0x52 sets the byte index, and a value at or above the block's byte count sets it to 0. A read of 0x52 returns the index. A write to 0x53 stores the byte at the index and moves the index up by one, wrapping to 0 at the block's byte count. A read of 0x53 returns the staged byte at the index.
- R7: On a frame with z_frame high, the staging buffer is copied to the active buffer and that frame sends bit 0 of the new content. Staging writes made between Z frames do not change the bits being sent.
- R8: Each Z-frame transfer sets the ready flag, which reads back as status bit 0 at address 0x54.
- R9: Once the accepted writes since the last transfer reach the capacity, the full flag (status bit 1) is set. Further data writes then change neither the staging buffer nor the index until the next transfer.
- R10: A read of address 0x54 returns the flags and then clears both of them, unless one of them is set again in that same cycle.
- R11: irq is high exactly when (ready AND mask_ready) OR (full AND mask_full).
- R12: After reset both flags are 0, the index is 0, user_bit is 0, irq is 0 and both buffers hold zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 8 | Host register address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, combinational from bus_addr |
| cfg_mode | input | 2 | Buffer mode (00 zero, 01 fill, 10 info-unit, 11 Q-subcode) |
| cfg_size | input | 1 | Block length select: 0 gives 384 bits, 1 gives 768 bits |
| mask_ready | input | 1 | Interrupt enable for the ready flag |
| mask_full | input | 1 | Interrupt enable for the full flag |
| frame_tick | input | 1 | One pulse per transmitted frame |
| z_frame | input | 1 | Marks a frame that carries the Z preamble |
| user_bit | output | 1 | User bit for the current frame, registered |
| irq | output | 1 | Masked interrupt |

## Verification
The bench uses the default parameters: a 48-byte short block, which makes the long block 96 bytes, and a 10-byte Q area. These values make both real block lengths reachable, so the wrap at 384 and at 768 frames can be counted out frame by frame. They also keep filling the short block to its full point down to 48 host writes. With a Q area of 10 bytes and a byte left over from an earlier block at position 10, the zeroing past the Q area shows up directly at user bit 80.

// File: rtl/ubuf_pkg.sv
package ubuf_pkg;

  typedef enum logic [1:0] {
    UB_ZERO = 2'b00,
    UB_FILL = 2'b01,
    UB_IU   = 2'b10,
    UB_QSUB = 2'b11
  } ub_mode_e;

  // Bytes in one block for the selected size.
  function automatic int ub_block_bytes(input logic size_sel, input int small_bytes);
    return size_sel ? 2 * small_bytes : small_bytes;
  endfunction

  // Accepted writes before the staging buffer counts as full.
  function automatic int ub_capacity(input ub_mode_e mode, input int blk_bytes, input int q_bytes);
    return (mode == UB_QSUB) ? q_bytes : blk_bytes;
  endfunction

  // Index after a data write, wrapping at the block's byte count.
  function automatic int ub_next_index(input int idx, input int blk_bytes);
    return (idx + 1 >= blk_bytes) ? 0 : idx + 1;
  endfunction

  // User bit for bit position pos of byte byte_idx holding data.
  function automatic logic ub_user_bit(input ub_mode_e mode, input int byte_idx,
                                       input logic [2:0] pos, input logic [7:0] data,
                                       input int q_bytes);
    logic b;
    case (mode)
      UB_ZERO: b = 1'b0;
      UB_FILL: b = data[pos];
      UB_IU:   b = (pos == 3'd0) ? 1'b1 : data[3'd7 - pos];
      default: b = (byte_idx < q_bytes) ? data[pos] : 1'b0;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/ubuf_host_ctrl.sv
module ubuf_host_ctrl
  import ubuf_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter logic [7:0] ADDR_IDX  = 8'h52,
  parameter logic [7:0] ADDR_DATA = 8'h53,
  parameter logic [7:0] ADDR_STAT = 8'h54
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  input  int               blk_bytes,
  input  int               cap_bytes,
  input  logic             xfer,
  input  logic [7:0]       store_rdata,
  output logic             mem_we,
  output logic [IDX_W-1:0] wr_index,
  output logic             staging_full,
  output logic             full_set,
  output logic             ready_flag,
  output logic             full_flag,
  output logic [7:0]       bus_rdata
);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W:0]   fill_q;
  logic             full_q, ready_q, fflag_q;
  logic             wr_data, wr_idx, stat_rd;

  assign wr_data  = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_idx   = bus_wr && (bus_addr == ADDR_IDX);
  assign stat_rd  = bus_rd && (bus_addr == ADDR_STAT);
  assign mem_we   = wr_data && !full_q;
  assign full_set = mem_we && ((int'(fill_q) + 1) == cap_bytes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (wr_idx) begin
      idx_q <= (int'(bus_wdata) < blk_bytes) ? IDX_W'(bus_wdata) : '0;
    end else if (mem_we) begin
      idx_q <= IDX_W'(ub_next_index(int'(idx_q), blk_bytes));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      full_q <= 1'b0;
    end else if (xfer) begin
      fill_q <= '0;
      full_q <= 1'b0;
    end else if (mem_we) begin
      fill_q <= fill_q + 1'b1;
      if (full_set) full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      fflag_q <= 1'b0;
    end else begin
      if (xfer)          ready_q <= 1'b1;
      else if (stat_rd)  ready_q <= 1'b0;
      if (full_set)      fflag_q <= 1'b1;
      else if (stat_rd)  fflag_q <= 1'b0;
    end
  end

  always_comb begin
    if (bus_addr == ADDR_IDX)       bus_rdata = {{(8-IDX_W){1'b0}}, idx_q};
    else if (bus_addr == ADDR_DATA) bus_rdata = store_rdata;
    else if (bus_addr == ADDR_STAT) bus_rdata = {6'b0, fflag_q, ready_q};
    else                            bus_rdata = 8'h00;
  end

  assign wr_index     = idx_q;
  assign staging_full = full_q;
  assign ready_flag   = ready_q;
  assign full_flag    = fflag_q;

endmodule

// File: rtl/ubuf_store.sv
module ubuf_store #(
  parameter int MAX_BYTES = 96,
  parameter int IDX_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wdata,
  input  logic             xfer,
  input  logic [IDX_W-1:0] ser_idx,
  output logic [7:0]       host_byte,
  output logic [7:0]       ser_byte,
  output logic [7:0]       stage_head
);

  logic [7:0] stage_q [MAX_BYTES];
  logic [7:0] act_q   [MAX_BYTES];

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= 8'h00;
      end else if (we && (widx == IDX_W'(g))) begin
        stage_q[g] <= wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q[g] <= 8'h00;
      end else if (xfer) begin
        act_q[g] <= stage_q[g];
      end
    end
  end

  assign host_byte  = (int'(widx) < MAX_BYTES) ? stage_q[widx] : 8'h00;
  assign ser_byte   = (int'(ser_idx) < MAX_BYTES) ? act_q[ser_idx] : 8'h00;
  assign stage_head = stage_q[0];

endmodule

// File: rtl/ubuf_serializer.sv
module ubuf_serializer
  import ubuf_pkg::*;
#(
  parameter int BIT_W   = 10,
  parameter int Q_BYTES = 10,
  localparam int IDX_W  = BIT_W - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             z_frame,
  input  ub_mode_e         mode,
  input  int               blk_bytes,
  input  logic [7:0]       ser_byte,
  input  logic [7:0]       stage_head,
  output logic [IDX_W-1:0] ser_idx,
  output logic             xfer,
  output logic             user_bit
);

  logic [BIT_W-1:0] ptr_q;
  logic             bit_q;
  int               blk_bits;

  assign blk_bits = blk_bytes * 8;
  assign xfer     = frame_tick && z_frame;
  assign ser_idx  = ptr_q[BIT_W-1:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      bit_q <= 1'b0;
    end else if (xfer) begin
      bit_q <= ub_user_bit(mode, 0, 3'd0, stage_head, Q_BYTES);
      ptr_q <= BIT_W'(1);
    end else if (frame_tick) begin
      bit_q <= ub_user_bit(mode, int'(ser_idx), ptr_q[2:0], ser_byte, Q_BYTES);
      ptr_q <= (int'(ptr_q) + 1 >= blk_bits) ? '0 : ptr_q + 1'b1;
    end
  end

  assign user_bit = bit_q;

endmodule

// File: rtl/ubuf_top.sv
module ubuf_top
  import ubuf_pkg::*;
#(
  parameter int SMALL_BYTES = 48,
  parameter int Q_BYTES     = 10,
  parameter logic [7:0] ADDR_IDX  = 8'h52,
  parameter logic [7:0] ADDR_DATA = 8'h53,
  parameter logic [7:0] ADDR_STAT = 8'h54,
  localparam int MAX_BYTES = 2 * SMALL_BYTES,
  localparam int IDX_W     = $clog2(MAX_BYTES),
  localparam int BIT_W     = $clog2(MAX_BYTES * 8)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_size,
  input  logic       mask_ready,
  input  logic       mask_full,
  input  logic       frame_tick,
  input  logic       z_frame,
  output logic       user_bit,
  output logic       irq
);

  ub_mode_e         mode;
  int               blk_bytes, cap_bytes;
  logic             mem_we, staging_full, full_set, ready_flag, full_flag, xfer;
  logic [IDX_W-1:0] wr_index, ser_idx;
  logic [7:0]       host_byte, ser_byte, stage_head;

  assign mode      = ub_mode_e'(cfg_mode);
  assign blk_bytes = ub_block_bytes(cfg_size, SMALL_BYTES);
  assign cap_bytes = ub_capacity(mode, blk_bytes, Q_BYTES);

  ubuf_host_ctrl #(
    .IDX_W(IDX_W), .ADDR_IDX(ADDR_IDX), .ADDR_DATA(ADDR_DATA), .ADDR_STAT(ADDR_STAT)
  ) u_host (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .blk_bytes(blk_bytes),
    .cap_bytes(cap_bytes), .xfer(xfer), .store_rdata(host_byte),
    .mem_we(mem_we), .wr_index(wr_index), .staging_full(staging_full),
    .full_set(full_set), .ready_flag(ready_flag), .full_flag(full_flag),
    .bus_rdata(bus_rdata)
  );

  ubuf_store #(.MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .widx(wr_index), .wdata(bus_wdata),
    .xfer(xfer), .ser_idx(ser_idx), .host_byte(host_byte), .ser_byte(ser_byte),
    .stage_head(stage_head)
  );

  ubuf_serializer #(.BIT_W(BIT_W), .Q_BYTES(Q_BYTES)) u_ser (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .z_frame(z_frame),
    .mode(mode), .blk_bytes(blk_bytes), .ser_byte(ser_byte),
    .stage_head(stage_head), .ser_idx(ser_idx), .xfer(xfer), .user_bit(user_bit)
  );

  assign irq = (ready_flag & mask_ready) | (full_flag & mask_full);

endmodule

// File: rtl/ubuf_checker.sv
module ubuf_checker #(
  parameter int IDX_W = 7,
  parameter logic [7:0] ADDR_DATA = 8'h53,
  parameter logic [7:0] ADDR_STAT = 8'h54
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [7:0]       bus_addr,
  input logic [1:0]       cfg_mode,
  input logic             mask_ready,
  input logic             mask_full,
  input logic             frame_tick,
  input logic             user_bit,
  input logic             irq,
  input logic             xfer,
  input logic             staging_full,
  input logic             full_set,
  input logic             ready_flag,
  input logic             full_flag,
  input logic [IDX_W-1:0] wr_index
);

  p_zero_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && cfg_mode == 2'b00) |=> !user_bit);

  p_iu_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cfg_mode == 2'b10) |=> user_bit);

  p_ready_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> ready_flag);

  p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (staging_full && bus_wr && bus_addr == ADDR_DATA) |=> $stable(wr_index));

  p_full_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full_set |=> (full_flag && staging_full));

  p_stat_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_STAT && !xfer && !full_set) |=> (!ready_flag && !full_flag));

  p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_ready && !mask_full) |-> !irq);

endmodule

bind ubuf_top ubuf_checker #(.IDX_W(IDX_W), .ADDR_DATA(ADDR_DATA), .ADDR_STAT(ADDR_STAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .cfg_mode(cfg_mode), .mask_ready(mask_ready), .mask_full(mask_full),
  .frame_tick(frame_tick), .user_bit(user_bit), .irq(irq), .xfer(xfer),
  .staging_full(staging_full), .full_set(full_set), .ready_flag(ready_flag),
  .full_flag(full_flag), .wr_index(wr_index)
);

// File: tb/ubuf_top_tb.sv
module ubuf_top_tb;

  localparam logic [7:0] A_IDX  = 8'h52;
  localparam logic [7:0] A_DATA = 8'h53;
  localparam logic [7:0] A_STAT = 8'h54;

  // {mode, byte written, expected 8 serial bits with the first sent in bit 0}
  localparam int NVEC = 7;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'b01, 8'hA5, 8'hA5},
    {2'b00, 8'hFF, 8'h00},
    {2'b10, 8'h35, 8'hAD},
    {2'b10, 8'h7F, 8'hFF},
    {2'b10, 8'h80, 8'h01},
    {2'b11, 8'h3C, 8'h3C},
    {2'b01, 8'h00, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] cfg_mode = 2'b01;
  logic       cfg_size = 1'b0;
  logic       mask_ready = 1'b0, mask_full = 1'b0;
  logic       frame_tick = 1'b0, z_frame = 1'b0;
  logic       user_bit, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ubuf_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_mode(cfg_mode),
    .cfg_size(cfg_size), .mask_ready(mask_ready), .mask_full(mask_full),
    .frame_tick(frame_tick), .z_frame(z_frame), .user_bit(user_bit), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic hr(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic tick(input logic z, output logic b);
    @(negedge clk);
    frame_tick = 1'b1; z_frame = z;
    @(posedge clk); #1;
    frame_tick = 1'b0; z_frame = 1'b0;
    b = user_bit;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic       b;
    logic [7:0] pat;
    string      tag;

    repeat (4) @(posedge clk);
    #1 chk("R12 user_bit", user_bit, 1'b0);
    chk("R12 irq", irq, 1'b0);
    rst_n = 1'b1;
    hr(A_IDX, rd);  chk("R12 index", rd, 8'h00);
    hr(A_DATA, rd); chk("R12 staging", rd, 8'h00);
    hr(A_STAT, rd); chk("R12 status", rd, 8'h00);
    tick(1'b0, b);  chk("R12 active zero", b, 1'b0);

    // Mode table walk
    for (int i = 0; i < NVEC; i++) begin
      cfg_mode = VEC[i][17:16];
      hw(A_IDX, 8'h00);
      hw(A_DATA, VEC[i][15:8]);
      tick(1'b1, b); pat[0] = b;
      for (int k = 1; k < 8; k++) begin
        tick(1'b0, b); pat[k] = b;
      end
      case (VEC[i][17:16])
        2'b00:   tag = "R1 zero mode";
        2'b01:   tag = "R2 fill mode";
        2'b10:   tag = "R4 info-unit";
        default: tag = "R5 q-subcode";
      endcase
      chk(tag, pat, VEC[i][7:0]);
    end

    // R6 index register
    cfg_mode = 2'b01; cfg_size = 1'b0;
    hw(A_IDX, 8'd5); hw(A_DATA, 8'h3C);
    hr(A_IDX, rd);  chk("R6 auto-increment", rd, 8'd6);
    hw(A_IDX, 8'd5);
    hr(A_DATA, rd); chk("R6 data readback", rd, 8'h3C);
    hw(A_IDX, 8'd47); hw(A_DATA, 8'h01);
    hr(A_IDX, rd);  chk("R6 wrap at 48", rd, 8'd0);
    hw(A_IDX, 8'd50);
    hr(A_IDX, rd);  chk("R6 out of range small", rd, 8'd0);
    cfg_size = 1'b1;
    hw(A_IDX, 8'd50);
    hr(A_IDX, rd);  chk("R6 in range large", rd, 8'd50);
    cfg_size = 1'b0;

    // R3 / R7 small block wrap, staging isolated from active
    hw(A_IDX, 8'd0); hw(A_DATA, 8'hA5);
    tick(1'b1, b); chk("R7 z frame bit0", b, 1'b1);
    hw(A_IDX, 8'd0); hw(A_DATA, 8'h00);
    for (int k = 0; k < 383; k++) tick(1'b0, b);
    tick(1'b0, b); chk("R3 wrap at 384 / R7 active kept", b, 1'b1);
    tick(1'b1, b); chk("R7 new block on z", b, 1'b0);

    // R3 large block
    cfg_size = 1'b1;
    hw(A_IDX, 8'd0);  hw(A_DATA, 8'h01);
    hw(A_IDX, 8'd48); hw(A_DATA, 8'h00);
    tick(1'b1, b); chk("R3 large bit0", b, 1'b1);
    for (int k = 0; k < 383; k++) tick(1'b0, b);
    tick(1'b0, b); chk("R3 no wrap at 384", b, 1'b0);
    for (int k = 0; k < 383; k++) tick(1'b0, b);
    tick(1'b0, b); chk("R3 wrap at 768", b, 1'b1);
    cfg_size = 1'b0;

    // R8 / R10 / R11 ready flag
    hr(A_STAT, rd);
    tick(1'b1, b);
    mask_ready = 1'b0; #1 chk("R11 ready masked", irq, 1'b0);
    mask_ready = 1'b1; #1 chk("R11 ready enabled", irq, 1'b1);
    hr(A_STAT, rd); chk("R8 ready status", rd, 8'h01);
    #1 chk("R10 irq after clear", irq, 1'b0);
    hr(A_STAT, rd); chk("R10 status cleared", rd, 8'h00);
    mask_ready = 1'b0;

    // R9 full flag and discarded writes
    hw(A_IDX, 8'd0);
    for (int i = 0; i < 48; i++) hw(A_DATA, 8'(i + 1));
    mask_full = 1'b1; #1 chk("R11 full enabled", irq, 1'b1);
    hr(A_STAT, rd); chk("R9 full status", rd, 8'h02);
    hw(A_DATA, 8'h77);
    hr(A_IDX, rd);  chk("R9 index held when full", rd, 8'd0);
    hr(A_DATA, rd); chk("R9 write discarded", rd, 8'h01);
    tick(1'b1, b);  chk("R9 block sent", b, 1'b1);
    hw(A_DATA, 8'h77);
    hw(A_IDX, 8'd0);
    hr(A_DATA, rd); chk("R9 write accepted after transfer", rd, 8'h77);
    mask_full = 1'b0;

    // R5 Q-subcode capacity and zeroing past byte 9
    cfg_mode = 2'b11;
    tick(1'b1, b);
    hr(A_STAT, rd);
    hw(A_IDX, 8'd0);
    for (int i = 0; i < 10; i++) hw(A_DATA, 8'hFF);
    hr(A_STAT, rd); chk("R5 full after 10", rd, 8'h02);
    tick(1'b1, b);  chk("R5 q byte0", b, 1'b1);
    for (int k = 0; k < 79; k++) tick(1'b0, b);
    tick(1'b0, b);  chk("R5 byte10 zero", b, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule